// File: doc/BRIEF.md
# Telemetry interrogation command decoder

This block sits on a telemetry bus. It receives serial interrogation words and works out whether each word is meant for this unit and which command it carries. Each word is 24 bits long, arrives most significant bit first, one bit per clock, and begins with a sync pulse. The block compares the word's terminal address with a locally strapped address. It then evaluates a memory load address field. Two strap inputs widen that field from 3 to 4 or 5 bits by taking bits away from the terminal address, so that one unit can answer on 2 or 4 neighbouring terminal addresses.

Acquisition and switch-closure commands run only when the evaluated memory load address is zero. A 16-bit serial acquisition needs two interrogations. The first one latches the parallel data word and the destination address. The second one completes the acquisition and starts a 21-bit response, which is shifted out one bit per response tick. If an acquisition or switch-closure command arrives as that second interrogation, it is a protocol violation: the block rejects it and raises a reject flag.

Word layout, bit 23 first: destination address [23:19], command code [18:15], memory load address base [14:12], terminal address [11:7], spare [6:0]. Command codes: 1 = 16-bit serial acquisition, 2 = single-interrogation acquisition, 3 = switch closure. All other codes carry no acquisition.

Top module: `tlm_icmd_dec`

## Requirements
- R1: A frame is the 24 bits sampled on the edge where `ser_sync_i` is high and the 23 edges that follow, most significant bit first. A sync during a frame restarts it. The frame is accepted only if `ser_val_i` is high on the edge that samples its last bit. A frame that is not accepted has no effect.
- R2: With both straps low, the frame is addressed only when all five terminal address bits [11:7] equal `local_ta_i`. The memory load address is bits [14:12].
- R3: With `mla_ext4_i` high and `mla_ext5_i` low, bit 11 is left out of the address comparison. The memory load address becomes the 4 bits [14:11].
- R4: With `mla_ext5_i` high, whatever `mla_ext4_i` is, bits 11 and 10 are left out of the address comparison. The memory load address becomes the 5 bits [14:10].
- R5: An addressed, accepted frame with code 1, 2 or 3 and a zero memory load address pulses `acq16_first_o`, `acq_o` or `swc_o` respectively, for one clock. A non-zero memory load address produces no strobe. Strobes are high in the clock cycle after the second rising edge that follows the last bit.
- R6: After `acq16_first_o`, the next addressed, accepted frame pulses `acq16_done_o`. It completes the sequence and produces no other strobe. Frames that are not addressed leave the sequence pending.
- R7: If that completing frame carries code 1, 2 or 3 with a zero memory load address, `reject_o` goes high and no acquisition or switch-closure strobe is produced. `reject_o` stays high until the next addressed, accepted frame that is not a violation.
- R8: On completion, the response frame is 21 bits: the destination address of the first interrogation, then the `par_data_i` value sampled when the first strobe was produced, most significant bit first. It appears on `rsp_dat_o` while `rsp_act_o` is high. Each clock with `rsp_tick_i` high advances it by one bit, it holds when `rsp_tick_i` is low, and `rsp_act_o` falls after the 21st tick.
- R9: Synchronous active-high `rst` clears the pending sequence, the reject flag, all strobes and the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_sync_i | input | 1 | High with the first bit of a frame |
| ser_dat_i | input | 1 | Serial interrogation data |
| ser_val_i | input | 1 | Frame valid, sampled with the last bit |
| mla_ext4_i | input | 1 | Strap: 4-bit memory load address |
| mla_ext5_i | input | 1 | Strap: 5-bit memory load address |
| local_ta_i | input | 5 | Local terminal address |
| par_data_i | input | 16 | Parallel data source for 16-bit acquisition |
| rsp_tick_i | input | 1 | Response bit advance |
| acq16_first_o | output | 1 | First half of 16-bit acquisition accepted |
| acq16_done_o | output | 1 | Second interrogation completed the sequence |
| acq_o | output | 1 | Single-interrogation acquisition strobe |
| swc_o | output | 1 | Switch-closure strobe |
| reject_o | output | 1 | Protocol violation flag |
| rsp_dat_o | output | 1 | Response serial data |
| rsp_act_o | output | 1 | Response frame in progress |

## Verification
The bench uses the default build: a 24-bit word, a 5-bit terminal address, a 3-bit base memory load address and 16-bit data. This configuration is small enough to sweep every terminal address pattern against every base memory load address value, under all four strap settings and two local addresses. That sweep covers every masked address comparison and every widened memory load address. Directed sequences then cover the two-interrogation acquisition, each kind of violation, reject clearing, frame rejection and restart, reset during a pending sequence, and the response bits with the response held between ticks.

// File: rtl/tlm_icmd_pkg.sv
package tlm_icmd_pkg;
  localparam int WORD_W  = 24;
  localparam int DEST_W  = 5;
  localparam int CMD_W   = 4;
  localparam int MLA_W   = 3;
  localparam int TA_W    = 5;
  localparam int DATA_W  = 16;
  localparam int EXT_MAX = 2;
  localparam int TA_LSB   = WORD_W - DEST_W - CMD_W - MLA_W - TA_W;
  localparam int MLA_LSB  = TA_LSB + TA_W;
  localparam int CMD_LSB  = MLA_LSB + MLA_W;
  localparam int DEST_LSB = CMD_LSB + CMD_W;
  localparam int RSP_W    = DEST_W + DATA_W;
  localparam int HDR_W    = WORD_W - TA_LSB;

  localparam logic [CMD_W-1:0] CMD_ACQ16 = CMD_W'(1);
  localparam logic [CMD_W-1:0] CMD_ACQ   = CMD_W'(2);
  localparam logic [CMD_W-1:0] CMD_SWC   = CMD_W'(3);
endpackage

// File: rtl/tlm_icmd_rx.sv
module tlm_icmd_rx
  import tlm_icmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_i,
  input  logic             dat_i,
  input  logic             val_i,
  output logic [HDR_W-1:0] hdr_o,
  output logic             frm_ok_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              rcv_q;
  logic              bit_last;

  assign bit_last = rcv_q && !sync_i && (cnt_q == LAST);
  assign hdr_o    = sh_q[WORD_W-1:TA_LSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      rcv_q    <= 1'b0;
      frm_ok_o <= 1'b0;
    end else begin
      frm_ok_o <= 1'b0;
      if (sync_i) begin
        sh_q  <= {sh_q[WORD_W-2:0], dat_i};
        cnt_q <= CNT_W'(1);
        rcv_q <= 1'b1;
      end else if (rcv_q) begin
        sh_q <= {sh_q[WORD_W-2:0], dat_i};
        if (bit_last) begin
          rcv_q    <= 1'b0;
          cnt_q    <= '0;
          frm_ok_o <= val_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R1: while receiving, the bit count stays within one frame
  p_frame_len_r1: assert property (@(posedge clk) disable iff (rst)
    rcv_q |-> (cnt_q >= CNT_W'(1)) && (cnt_q <= LAST));
  // R1: an accepted frame only follows the last bit of a frame
  p_ok_after_last_r1: assert property (@(posedge clk) disable iff (rst)
    frm_ok_o |-> !rcv_q || $past(sync_i));
endmodule

// File: rtl/tlm_icmd_decode.sv
module tlm_icmd_decode
  import tlm_icmd_pkg::*;
(
  input  logic [TA_W-1:0]  ta_i,
  input  logic [MLA_W-1:0] mla_i,
  input  logic [TA_W-1:0]  local_ta_i,
  input  logic             ext4_i,
  input  logic             ext5_i,
  output logic             addressed_o,
  output logic             mla_zero_o
);
  // Number of terminal address bits taken over by the memory load address
  function automatic int ext_bits(input logic e4, input logic e5);
    if (e5) return EXT_MAX;
    if (e4) return 1;
    return 0;
  endfunction

  // Mask of terminal address bits still compared (the top ones are taken first)
  function automatic logic [TA_W-1:0] ta_keep(input int n);
    logic [TA_W-1:0] m;
    m = '1;
    for (int i = 0; i < EXT_MAX; i++)
      if (i < n) m[TA_W-1-i] = 1'b0;
    return m;
  endfunction

  // Evaluated memory load address is non-zero
  function automatic logic mla_nz(input logic [MLA_W-1:0] base,
                                  input logic [TA_W-1:0] ta, input int n);
    logic nz;
    nz = |base;
    for (int i = 0; i < EXT_MAX; i++)
      if (i < n) nz = nz | ta[TA_W-1-i];
    return nz;
  endfunction

  int n_ext;
  assign n_ext       = ext_bits(ext4_i, ext5_i);
  assign addressed_o = ~|((ta_i ^ local_ta_i) & ta_keep(n_ext));
  assign mla_zero_o  = !mla_nz(mla_i, ta_i, n_ext);
endmodule

// File: rtl/tlm_icmd_seq.sv
module tlm_icmd_seq
  import tlm_icmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_ok_i,
  input  logic              addressed_i,
  input  logic              mla_zero_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [DEST_W-1:0] dest_i,
  input  logic [DATA_W-1:0] par_data_i,
  output logic              first_o,
  output logic              done_o,
  output logic              acq_o,
  output logic              swc_o,
  output logic              reject_o,
  output logic              load_o,
  output logic [RSP_W-1:0]  rsp_word_o
);
  logic              pend_q;
  logic [DEST_W-1:0] dest_q;
  logic [DATA_W-1:0] data_q;
  logic              hit;
  logic              live;
  logic              viol;

  assign hit        = frm_ok_i && addressed_i;
  assign live       = mla_zero_i &&
                      (cmd_i == CMD_ACQ16 || cmd_i == CMD_ACQ || cmd_i == CMD_SWC);
  assign viol       = hit && pend_q && live;
  assign load_o     = hit && pend_q;
  assign rsp_word_o = {dest_q, data_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      dest_q   <= '0;
      data_q   <= '0;
      first_o  <= 1'b0;
      done_o   <= 1'b0;
      acq_o    <= 1'b0;
      swc_o    <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      first_o <= 1'b0;
      done_o  <= 1'b0;
      acq_o   <= 1'b0;
      swc_o   <= 1'b0;
      if (hit) begin
        if (pend_q) begin
          pend_q   <= 1'b0;
          done_o   <= 1'b1;
          reject_o <= viol;
        end else begin
          reject_o <= 1'b0;
          if (live) begin
            unique case (cmd_i)
              CMD_ACQ16: begin
                first_o <= 1'b1;
                pend_q  <= 1'b1;
                dest_q  <= dest_i;
                data_q  <= par_data_i;
              end
              CMD_ACQ: acq_o <= 1'b1;
              default: swc_o <= 1'b1;
            endcase
          end
        end
      end
    end
  end

  // R5: at most one command strobe per cycle
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({first_o, done_o, acq_o, swc_o}));
  // R5: a non-zero memory load address starts nothing
  p_mla_block_r5: assert property (@(posedge clk) disable iff (rst)
    (hit && !mla_zero_i) |=> !first_o && !acq_o && !swc_o);
  // R6: the pending sequence is only entered with a first-half strobe
  p_pend_entry_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> first_o);
  // R7: a violation raises reject and completes without a command strobe
  p_viol_reject_r7: assert property (@(posedge clk) disable iff (rst)
    viol |=> reject_o && done_o && !acq_o && !swc_o && !first_o);
  // R9: reset clears the sequence and the flag
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> !reject_o && !pend_q && !done_o);
endmodule

// File: rtl/tlm_icmd_tx.sv
module tlm_icmd_tx
  import tlm_icmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [RSP_W-1:0] frame_i,
  input  logic             tick_i,
  output logic             dat_o,
  output logic             act_o
);
  localparam int CNT_W = $clog2(RSP_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RSP_W - 1);

  logic [RSP_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;

  assign dat_o = act_o & sh_q[RSP_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_o <= 1'b0;
    end else if (load_i) begin
      sh_q  <= frame_i;
      cnt_q <= '0;
      act_o <= 1'b1;
    end else if (act_o && tick_i) begin
      sh_q <= {sh_q[RSP_W-2:0], 1'b0};
      if (cnt_q == LAST) begin
        act_o <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R8: the bit count never passes the frame length
  p_len_r8: assert property (@(posedge clk) disable iff (rst)
    act_o |-> cnt_q <= LAST);
  // R8: the response holds between ticks
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (act_o && !tick_i && !load_i) |=> $stable(sh_q) && act_o);
endmodule

// File: rtl/tlm_icmd_dec.sv
module tlm_icmd_dec
  import tlm_icmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_sync_i,
  input  logic              ser_dat_i,
  input  logic              ser_val_i,
  input  logic              mla_ext4_i,
  input  logic              mla_ext5_i,
  input  logic [TA_W-1:0]   local_ta_i,
  input  logic [DATA_W-1:0] par_data_i,
  input  logic              rsp_tick_i,
  output logic              acq16_first_o,
  output logic              acq16_done_o,
  output logic              acq_o,
  output logic              swc_o,
  output logic              reject_o,
  output logic              rsp_dat_o,
  output logic              rsp_act_o
);
  logic [HDR_W-1:0]  hdr;
  logic              frm_ok;
  logic [TA_W-1:0]   ta_f;
  logic [MLA_W-1:0]  mla_f;
  logic [CMD_W-1:0]  cmd_f;
  logic [DEST_W-1:0] dest_f;
  logic              addressed;
  logic              mla_zero;
  logic              rsp_load;
  logic [RSP_W-1:0]  rsp_word;

  assign ta_f   = hdr[TA_LSB-TA_LSB +: TA_W];
  assign mla_f  = hdr[MLA_LSB-TA_LSB +: MLA_W];
  assign cmd_f  = hdr[CMD_LSB-TA_LSB +: CMD_W];
  assign dest_f = hdr[DEST_LSB-TA_LSB +: DEST_W];

  tlm_icmd_rx u_rx (
    .clk      (clk),
    .rst      (rst),
    .sync_i   (ser_sync_i),
    .dat_i    (ser_dat_i),
    .val_i    (ser_val_i),
    .hdr_o    (hdr),
    .frm_ok_o (frm_ok)
  );

  tlm_icmd_decode u_dec (
    .ta_i        (ta_f),
    .mla_i       (mla_f),
    .local_ta_i  (local_ta_i),
    .ext4_i      (mla_ext4_i),
    .ext5_i      (mla_ext5_i),
    .addressed_o (addressed),
    .mla_zero_o  (mla_zero)
  );

  tlm_icmd_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .frm_ok_i    (frm_ok),
    .addressed_i (addressed),
    .mla_zero_i  (mla_zero),
    .cmd_i       (cmd_f),
    .dest_i      (dest_f),
    .par_data_i  (par_data_i),
    .first_o     (acq16_first_o),
    .done_o      (acq16_done_o),
    .acq_o       (acq_o),
    .swc_o       (swc_o),
    .reject_o    (reject_o),
    .load_o      (rsp_load),
    .rsp_word_o  (rsp_word)
  );

  tlm_icmd_tx u_tx (
    .clk     (clk),
    .rst     (rst),
    .load_i  (rsp_load),
    .frame_i (rsp_word),
    .tick_i  (rsp_tick_i),
    .dat_o   (rsp_dat_o),
    .act_o   (rsp_act_o)
  );

  // R2: a strobe only follows an accepted frame two edges earlier
  p_strobe_src_r2: assert property (@(posedge clk) disable iff (rst)
    (acq_o || swc_o || acq16_first_o) |-> $past(frm_ok && addressed));
endmodule

// File: tb/tlm_icmd_dec_tb_top.sv
`timescale 1ns/1ps
module tlm_icmd_dec_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_i = 1'b0, dat_i = 1'b0, val_i = 1'b0;
  logic        e4 = 1'b0, e5 = 1'b0;
  logic [4:0]  loc_ta = 5'b10110;
  logic [15:0] pdata = 16'h0000;
  logic        tick = 1'b0;
  logic        first_o, done_o, acq_o, swc_o, rej_o, rdat_o, ract_o;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  tlm_icmd_dec dut_i (
    .clk(clk), .rst(rst), .ser_sync_i(sync_i), .ser_dat_i(dat_i),
    .ser_val_i(val_i), .mla_ext4_i(e4), .mla_ext5_i(e5),
    .local_ta_i(loc_ta), .par_data_i(pdata), .rsp_tick_i(tick),
    .acq16_first_o(first_o), .acq16_done_o(done_o), .acq_o(acq_o),
    .swc_o(swc_o), .reject_o(rej_o), .rsp_dat_o(rdat_o), .rsp_act_o(ract_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(input logic [4:0] dest, input logic [3:0] cmd,
                                     input logic [2:0] mla, input logic [4:0] ta);
    return {dest, cmd, mla, ta, 7'h2A};
  endfunction

  // Drive a frame; returns at the sampling point where strobes are visible
  task automatic send(input logic [23:0] w, input logic v);
    for (int i = 23; i >= 0; i--) begin
      @(negedge clk);
      sync_i = (i == 23);
      dat_i  = w[i];
      val_i  = v;
    end
    @(negedge clk);
    sync_i = 1'b0; dat_i = 1'b0; val_i = 1'b0;
    @(negedge clk);
  endtask

  // vector {first, done, acq, swc, reject}
  function automatic logic [4:0] outs();
    return {first_o, done_o, acq_o, swc_o, rej_o};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [20:0] rexp;
    int w;
    logic [4:0] mv;
    logic hit_e, nz_e;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset outputs", {27'd0, outs()}, 32'd0);
    chk("R9 reset response", {30'd0, ract_o, rdat_o}, 32'd0);
    rst = 1'b0;

    // R2 R3 R4 R5: sweep straps, addresses and memory load address with switch closure
    for (int l = 0; l < 2; l++) begin
      loc_ta = (l == 0) ? 5'b10110 : 5'b01001;
      for (int s = 0; s < 4; s++) begin
        e4 = s[0]; e5 = s[1];
        w = e5 ? 5 : (e4 ? 4 : 3);
        for (int t = 0; t < 32; t++) begin
          for (int m = 0; m < 8; m++) begin
            mv    = 5'(({m[2:0], 2'(t >> 3)}) >> (5 - w));
            nz_e  = (mv != 0);
            hit_e = ((((t ^ loc_ta) % (1 << (8 - w)))) == 0);
            send(mk(5'h03, 4'd3, 3'(m), 5'(t)), 1'b1);
            chk(e5 ? "R4 sweep" : (e4 ? "R3 sweep" : "R2 R5 sweep"),
                {27'd0, outs()}, {27'd0, 3'b000, hit_e && !nz_e, 1'b0});
          end
        end
      end
    end
    e4 = 0; e5 = 0; loc_ta = 5'b10110;

    // R5: acquisition with zero and non-zero memory load address
    send(mk(5'h01, 4'd2, 3'd0, 5'b10110), 1'b1);
    chk("R5 acq zero mla", {27'd0, outs()}, 32'b00100);
    send(mk(5'h01, 4'd2, 3'd4, 5'b10110), 1'b1);
    chk("R5 acq nonzero mla", {27'd0, outs()}, 32'd0);
    send(mk(5'h01, 4'd1, 3'd1, 5'b10110), 1'b1);
    chk("R5 acq16 nonzero mla", {27'd0, outs()}, 32'd0);
    send(mk(5'h01, 4'd2, 3'd0, 5'b10110), 1'b1);
    chk("R6 no pending after blocked acq16", {27'd0, outs()}, 32'b00100);

    // R1: invalid frame ignored, restart by sync
    send(mk(5'h01, 4'd3, 3'd0, 5'b10110), 1'b0);
    chk("R1 invalid frame", {27'd0, outs()}, 32'd0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); sync_i = (i == 0); dat_i = 1'b1; val_i = 1'b1;
    end
    send(mk(5'h01, 4'd3, 3'd0, 5'b10110), 1'b1);
    chk("R1 restart by sync", {27'd0, outs()}, 32'b00010);

    // R6 R8: two-interrogation acquisition and response
    pdata = 16'hA5C3;
    send(mk(5'h15, 4'd1, 3'd0, 5'b10110), 1'b1);
    chk("R6 first half", {27'd0, outs()}, 32'b10000);
    pdata = 16'h1234;
    send(mk(5'h0A, 4'd2, 3'd0, 5'b01111), 1'b1);
    chk("R6 unaddressed keeps pending", {27'd0, outs()}, 32'd0);
    send(mk(5'h0A, 4'd7, 3'd0, 5'b10110), 1'b1);
    chk("R6 completion", {27'd0, outs()}, 32'b01000);
    chk("R8 response active", {31'd0, ract_o}, 32'd1);
    rexp = {5'h15, 16'hA5C3};
    repeat (3) @(negedge clk);
    chk("R8 hold without tick", {31'd0, rdat_o}, {31'd0, rexp[20]});
    for (int k = 0; k < 21; k++) begin
      chk("R8 response bit", {31'd0, rdat_o}, {31'd0, rexp[20 - k]});
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
    chk("R8 response length", {31'd0, ract_o}, 32'd0);

    // R7: each violating command as second interrogation
    for (int c = 1; c <= 3; c++) begin
      send(mk(5'h02, 4'd1, 3'd0, 5'b10110), 1'b1);
      chk("R7 setup first", {27'd0, outs()}, 32'b10000);
      send(mk(5'h02, 4'(c), 3'd0, 5'b10110), 1'b1);
      chk("R7 violation rejected", {27'd0, outs()}, 32'b01001);
      send(mk(5'h02, 4'd2, 3'd0, 5'b01100), 1'b1);
      chk("R7 reject held on unaddressed", {27'd0, outs()}, 32'b00001);
      send(mk(5'h02, 4'd3, 3'd0, 5'b10110), 1'b1);
      chk("R7 reject cleared", {27'd0, outs()}, 32'b00010);
    end
    // R7: non-zero mla second command is not a violation
    send(mk(5'h02, 4'd1, 3'd0, 5'b10110), 1'b1);
    send(mk(5'h02, 4'd2, 3'd5, 5'b10110), 1'b1);
    chk("R7 nonzero mla completes", {27'd0, outs()}, 32'b01000);

    // R9: reset during pending sequence
    send(mk(5'h02, 4'd1, 3'd0, 5'b10110), 1'b1);
    do_reset();
    chk("R9 reset clears", {27'd0, outs()}, 32'd0);
    send(mk(5'h02, 4'd2, 3'd0, 5'b10110), 1'b1);
    chk("R9 no pending after reset", {27'd0, outs()}, 32'b00100);
    send(mk(5'h02, 4'd1, 3'd0, 5'b10110), 1'b1);
    send(mk(5'h02, 4'd2, 3'd0, 5'b10110), 1'b1);
    do_reset();
    chk("R9 reject and response cleared", {30'd0, rej_o, ract_o}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule